// File: doc/BRIEF.md
# Stale-Value Invalidation Buffer

This block keeps, for one processor of a weakly ordered multiprocessor, the set of memory values that the processor is still allowed to observe even though they have been overwritten in memory. Each time another processor drains a store to some address, the value it replaced is offered to this buffer as a new, youngest entry. The processor's loads that missed its own store buffer may then return either the current memory value or one of these stale entries. The buffer prunes itself after every load so that the processor never sees a value older than one it has already seen at that address.

Entries live in one age-ordered array, with slot 0 the oldest. Because age order over all entries implies age order among the entries of any one address, same-address entries behave as a FIFO. A local store to an address removes every entry for that address. A Reconcile fence empties the buffer. An insert is dropped when the local store buffer already holds the address. When the buffer is full, an insert evicts the oldest entry of all. Every update takes effect at the clock edge. Within a cycle all removals are worked out against the current contents first, and the insert is applied after them.

Each load is resolved into one of four named outcomes. LK_IDLE means there is no load. LK_MEMORY means the memory value was chosen. LK_STALE means a matching entry was found and returned. LK_FALLBACK means a stale entry was requested but the index matched nothing, so the memory value is returned. The outcome holds for the cycle of the load only. It is decided combinationally from the load inputs and the current contents, and it picks both the returned data and the set of entries removed at the next edge.

Top module: `stale_ib`

## Requirements
- R1: After reset the buffer is empty (`empty`=1), and a load requesting a stale entry returns `ld_mem_data` with `ld_from_stale`=0.
- R2: An insert with `ins_sb_hit`=0 appends (`ins_addr`, `ins_data`) as the youngest entry. A stale load with index k returns the k-th oldest entry for `ld_addr`, where index 0 means the oldest.
- R3: An insert with `ins_sb_hit`=1 adds no entry.
- R4: A local store (`st_valid`) removes every entry whose address equals `st_addr`.
- R5: A Reconcile fence (`rec_valid`) removes all entries.
- R6: A load with `ld_use_stale`=0 returns `ld_mem_data` with `ld_from_stale`=0, and removes every entry for `ld_addr`.
- R7: A load with `ld_use_stale`=1 whose index selects an entry returns that entry's value with `ld_from_stale`=1. It removes the entries for `ld_addr` older than the selected one and keeps the selected entry and the younger ones.
- R8: A load with `ld_use_stale`=1 whose index is not below the number of entries for `ld_addr` returns `ld_mem_data` with `ld_from_stale`=0, and removes every entry for `ld_addr`.
- R9: An insert into a buffer holding DEPTH entries, with nothing removed in that cycle, drops the oldest entry of all and appends the new one.
- R10: Removals in a cycle are evaluated on the contents before the edge, and the insert is applied after them. An insert to the address being purged in the same cycle therefore survives.
- R11: Loads and local stores leave the entries of other addresses unchanged and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Another processor drained a store; offer the overwritten value |
| ins_sb_hit | input | 1 | Local store buffer already holds `ins_addr`; suppress insert |
| ins_addr | input | AW | Address of the drained store |
| ins_data | input | DW | Memory value that the drain overwrote |
| st_valid | input | 1 | Local store executes |
| st_addr | input | AW | Local store address |
| rec_valid | input | 1 | Reconcile fence executes |
| ld_valid | input | 1 | Load that missed the store buffer executes |
| ld_addr | input | AW | Load address |
| ld_mem_data | input | DW | Current memory value at `ld_addr` |
| ld_use_stale | input | 1 | 1 requests a stale entry, 0 requests memory |
| ld_pick | input | IW | Index among the entries for `ld_addr`, 0 = oldest |
| ld_data | output | DW | Value returned to the load |
| ld_from_stale | output | 1 | Returned value came from the buffer |
| empty | output | 1 | Buffer holds no entries |

## Verification
On every cycle the assertions check the occupancy bounds and the pure occupancy effects. An uncontested insert grows the buffer by one, a suppressed insert never grows it, a full buffer stays full on insert, and a Reconcile with no insert leaves it empty. They also check that a memory-choice load returns the memory value. Only the bench's reference model can show which entries survive, in what order, and which value a stale load returns after a chain of inserts, purges and prunes. That covers the per-address FIFO order, partial pruning below the selected entry, the index fallback, eviction of the oldest entry and same-cycle purge-then-insert ordering.

// File: rtl/sib_pkg.sv
package sib_pkg;
    typedef enum logic [1:0] {
        LK_IDLE,
        LK_MEMORY,
        LK_STALE,
        LK_FALLBACK
    } ld_kind_e;
endpackage

// File: rtl/sib_select.sv
module sib_select
    import sib_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int IW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic [AW-1:0] ent_addr [DEPTH],
    input  logic [DW-1:0] ent_data [DEPTH],
    input  logic [CW-1:0] fill,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_mem_data,
    input  logic          ld_use_stale,
    input  logic [IW-1:0] ld_pick,
    output logic [DEPTH-1:0] drop_vec,
    output logic [DW-1:0] ld_data,
    output logic          ld_from_stale
);
    logic [DEPTH-1:0] hit_vec;
    logic [DEPTH-1:0] below_sel;
    logic [IW-1:0]    sel_idx;
    logic             sel_found;
    logic [CW-1:0]    run;
    ld_kind_e         kind;

    // locate the ld_pick-th oldest entry for the load address
    always_comb begin
        run       = '0;
        sel_found = 1'b0;
        sel_idx   = '0;
        hit_vec   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            hit_vec[i] = (CW'(i) < fill) && (ent_addr[i] == ld_addr);
            if (hit_vec[i] && !sel_found && run == CW'(ld_pick)) begin
                sel_found = 1'b1;
                sel_idx   = IW'(i);
            end
            if (hit_vec[i]) run = run + 1'b1;
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) below_sel[i] = (IW'(i) < sel_idx);
    end

    // outcome decision
    always_comb begin
        if (!ld_valid)         kind = LK_IDLE;
        else if (!ld_use_stale) kind = LK_MEMORY;
        else if (sel_found)    kind = LK_STALE;
        else                   kind = LK_FALLBACK;
    end

    // outcome actions
    always_comb begin
        unique case (kind)
            LK_STALE: begin
                ld_data       = ent_data[sel_idx];
                ld_from_stale = 1'b1;
                drop_vec      = hit_vec & below_sel;
            end
            LK_MEMORY, LK_FALLBACK: begin
                ld_data       = ld_mem_data;
                ld_from_stale = 1'b0;
                drop_vec      = hit_vec;
            end
            default: begin
                ld_data       = ld_mem_data;
                ld_from_stale = 1'b0;
                drop_vec      = '0;
            end
        endcase
    end
endmodule

// File: rtl/sib_compact.sv
module sib_compact #(
    parameter int DEPTH = 8,
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int IW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] keep,
    input  logic             ins_en,
    input  logic [AW-1:0]    ins_addr,
    input  logic [DW-1:0]    ins_data,
    output logic [AW-1:0]    ent_addr [DEPTH],
    output logic [DW-1:0]    ent_data [DEPTH],
    output logic [CW-1:0]    fill
);
    logic [AW-1:0] c_addr [DEPTH];
    logic [DW-1:0] c_data [DEPTH];
    logic [AW-1:0] n_addr [DEPTH];
    logic [DW-1:0] n_data [DEPTH];
    logic [CW-1:0] rank;
    logic [CW-1:0] n_fill;

    // squeeze surviving entries toward slot 0, preserving age order
    always_comb begin
        rank = '0;
        for (int j = 0; j < DEPTH; j++) begin
            c_addr[j] = '0;
            c_data[j] = '0;
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (keep[i]) begin
                c_addr[rank[IW-1:0]] = ent_addr[i];
                c_data[rank[IW-1:0]] = ent_data[i];
                rank = rank + 1'b1;
            end
        end
    end

    // append after the removals; evict slot 0 when no room is left
    always_comb begin
        n_addr = c_addr;
        n_data = c_data;
        n_fill = rank;
        if (ins_en) begin
            if (rank == CW'(DEPTH)) begin
                for (int j = 0; j < DEPTH - 1; j++) begin
                    n_addr[j] = c_addr[j+1];
                    n_data[j] = c_data[j+1];
                end
                n_addr[DEPTH-1] = ins_addr;
                n_data[DEPTH-1] = ins_data;
            end else begin
                n_addr[rank[IW-1:0]] = ins_addr;
                n_data[rank[IW-1:0]] = ins_data;
                n_fill = rank + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill <= '0;
            for (int j = 0; j < DEPTH; j++) begin
                ent_addr[j] <= '0;
                ent_data[j] <= '0;
            end
        end else begin
            fill     <= n_fill;
            ent_addr <= n_addr;
            ent_data <= n_data;
        end
    end
endmodule

// File: rtl/stale_ib.sv
module stale_ib #(
    parameter int DEPTH = 8,
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int IW    = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ins_valid,
    input  logic          ins_sb_hit,
    input  logic [AW-1:0] ins_addr,
    input  logic [DW-1:0] ins_data,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic          rec_valid,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_mem_data,
    input  logic          ld_use_stale,
    input  logic [IW-1:0] ld_pick,
    output logic [DW-1:0] ld_data,
    output logic          ld_from_stale,
    output logic          empty
);
    logic [AW-1:0]    ent_addr [DEPTH];
    logic [DW-1:0]    ent_data [DEPTH];
    logic [CW-1:0]    fill;
    logic [DEPTH-1:0] drop_vec;
    logic [DEPTH-1:0] st_vec;
    logic [DEPTH-1:0] live_vec;
    logic [DEPTH-1:0] keep;
    logic             ins_en;

    assign ins_en = ins_valid && !ins_sb_hit;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            live_vec[i] = CW'(i) < fill;
            st_vec[i]   = st_valid && (ent_addr[i] == st_addr);
        end
        keep = rec_valid ? '0 : (live_vec & ~drop_vec & ~st_vec);
    end

    sib_select #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .IW(IW), .CW(CW)) u_select (
        .ent_addr     (ent_addr),
        .ent_data     (ent_data),
        .fill         (fill),
        .ld_valid     (ld_valid),
        .ld_addr      (ld_addr),
        .ld_mem_data  (ld_mem_data),
        .ld_use_stale (ld_use_stale),
        .ld_pick      (ld_pick),
        .drop_vec     (drop_vec),
        .ld_data      (ld_data),
        .ld_from_stale(ld_from_stale)
    );

    sib_compact #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .IW(IW), .CW(CW)) u_compact (
        .clk     (clk),
        .rst_n   (rst_n),
        .keep    (keep),
        .ins_en  (ins_en),
        .ins_addr(ins_addr),
        .ins_data(ins_data),
        .ent_addr(ent_addr),
        .ent_data(ent_data),
        .fill    (fill)
    );

    assign empty = (fill == '0);

    a_r1_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));

    a_r2_insert_grows: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en && !rec_valid && !st_valid && !ld_valid && fill < CW'(DEPTH)
        |=> fill == $past(fill) + 1'b1);

    a_r3_suppressed_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && ins_sb_hit |=> fill <= $past(fill));

    a_r5_reconcile_empties: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && !ins_en |=> empty);

    a_r6_memory_choice: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid && !ld_use_stale |-> (ld_data == ld_mem_data) && !ld_from_stale);

    a_r9_full_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en && fill == CW'(DEPTH) && !rec_valid && !st_valid && !ld_valid
        |=> fill == CW'(DEPTH));
endmodule

// File: tb/sim_stale_ib.sv
module sim_stale_ib;
    localparam int DEPTH = 4;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ins_valid = 0, ins_sb_hit = 0, st_valid = 0, rec_valid = 0;
    logic ld_valid = 0, ld_use_stale = 0;
    logic [AW-1:0] ins_addr = '0, st_addr = '0, ld_addr = '0;
    logic [DW-1:0] ins_data = '0, ld_mem_data = '0;
    logic [IW-1:0] ld_pick = '0;
    logic [DW-1:0] ld_data;
    logic ld_from_stale, empty;

    int checks = 0;
    int fails = 0;
    int qa[$];
    int qd[$];

    always #10 clk = ~clk;

    stale_ib #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .IW(IW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_sb_hit(ins_sb_hit), .ins_addr(ins_addr), .ins_data(ins_data),
        .st_valid(st_valid), .st_addr(st_addr), .rec_valid(rec_valid),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_mem_data(ld_mem_data),
        .ld_use_stale(ld_use_stale), .ld_pick(ld_pick),
        .ld_data(ld_data), .ld_from_stale(ld_from_stale), .empty(empty)
    );

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // one clock: drive, compare against the queue model, then advance the model
    task automatic step(input bit iv, input bit sbh, input int ia, input int id,
                        input bit sv, input int sa, input bit rv,
                        input bit lv, input int la, input int lm, input bit lu, input int lp,
                        input string tag);
        int m[$];
        bit keep[$];
        int sel;
        int ta[$];
        int td[$];
        @(negedge clk);
        ins_valid = iv; ins_sb_hit = sbh; ins_addr = AW'(ia); ins_data = DW'(id);
        st_valid = sv; st_addr = AW'(sa); rec_valid = rv;
        ld_valid = lv; ld_addr = AW'(la); ld_mem_data = DW'(lm);
        ld_use_stale = lu; ld_pick = IW'(lp);
        #1;
        check(tag, int'(empty), (qa.size() == 0) ? 1 : 0, "empty");
        foreach (qa[i]) if (qa[i] == la) m.push_back(i);
        sel = (lv && lu && lp < m.size()) ? m[lp] : -1;
        if (lv) begin
            check(tag, int'(ld_data), (sel >= 0) ? qd[sel] : lm, "ld_data");
            check(tag, int'(ld_from_stale), (sel >= 0) ? 1 : 0, "ld_from_stale");
        end
        foreach (qa[i]) begin
            bit k;
            k = !rv;
            if (sv && qa[i] == sa) k = 0;
            if (lv && qa[i] == la && (sel < 0 || i < sel)) k = 0;
            keep.push_back(k);
        end
        foreach (qa[i]) if (keep[i]) begin ta.push_back(qa[i]); td.push_back(qd[i]); end
        qa = ta; qd = td;
        if (iv && !sbh) begin
            if (qa.size() == DEPTH) begin void'(qa.pop_front()); void'(qd.pop_front()); end
            qa.push_back(ia); qd.push_back(id);
        end
    endtask

    task automatic ins(input int a, input int d, input string tag);
        step(1, 0, a, d, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic ld(input int a, input int mem, input bit use_st, input int pick, input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 1, a, mem, use_st, pick, tag);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        ld(5, 77, 1, 0, "R1");
        // R2: FIFO order for one address
        ins(5, 100, "R2"); ins(5, 101, "R2"); ins(6, 200, "R2");
        ld(5, 9, 1, 1, "R7");   // returns 101, drops 100
        ld(5, 9, 1, 0, "R7");   // 101 still present
        ld(6, 9, 1, 0, "R11");  // other address untouched
        ld(5, 9, 0, 0, "R6");   // memory read purges address 5
        ld(5, 9, 1, 0, "R6");
        ld(6, 9, 1, 0, "R11");
        // R3: suppressed insert
        step(1, 1, 7, 300, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
        ld(7, 1, 1, 0, "R3");
        // R4: local store purge, others kept
        ins(8, 10, "R4"); ins(8, 11, "R4");
        step(0, 0, 0, 0, 1, 8, 0, 0, 0, 0, 0, 0, "R4");
        ld(8, 2, 1, 0, "R4");
        ld(6, 2, 1, 0, "R11");
        // R5: reconcile
        ins(9, 50, "R5");
        step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R5");
        idle("R5");
        // R8: index beyond matches falls back and purges
        ins(3, 30, "R8"); ins(3, 31, "R8");
        ld(3, 44, 1, 3, "R8");
        ld(3, 44, 1, 0, "R8");
        // R9: overflow evicts oldest
        ins(1, 1, "R9"); ins(2, 2, "R9"); ins(3, 3, "R9"); ins(4, 4, "R9"); ins(1, 5, "R9");
        ld(1, 0, 1, 0, "R9");
        ld(2, 0, 1, 0, "R9");
        // R10: purge and insert same address same cycle
        step(1, 0, 4, 99, 1, 4, 0, 0, 0, 0, 0, 0, "R10");
        ld(4, 0, 1, 0, "R10");
        step(1, 0, 2, 77, 0, 0, 1, 0, 0, 0, 0, 0, "R10");
        ld(2, 0, 1, 0, "R10");
        // mixed stream
        for (int n = 0; n < 400; n++) begin
            step($urandom_range(1, 0), $urandom_range(4, 0) == 0, $urandom_range(3, 0),
                 $urandom_range(999, 0), $urandom_range(6, 0) == 0, $urandom_range(3, 0),
                 $urandom_range(19, 0) == 0, $urandom_range(1, 0), $urandom_range(3, 0),
                 $urandom_range(999, 0), $urandom_range(3, 0) != 0, $urandom_range(3, 0),
                 "R2_R7_mix");
        end
        idle("R1");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule